// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Flags

This block combines two operands under a three-bit operation code and returns a result together with six condition flags: carry, overflow, sign, zero, nibble carry (carry out of bit 3 into bit 4) and even parity. It supports addition, subtraction, AND, OR and XOR. The result and a live copy of the flags are combinational. A flag-write strobe captures the flags into a status register.

Carry and overflow are derived separately, so each of the four combinations can appear. An unsigned range error sets carry. A signed range error sets overflow. Logic operations clear the arithmetic flags and derive the rest from the result.

The status register clears asynchronously when reset goes low. It leaves reset through a two-stage synchronizer.

Top module: `stat_alu`

## Requirements
- R1: With operation code 0 (add), `result` is (`op_a` + `op_b`) mod 256, and the carry flag is the bit shifted out of the top bit (for example 0Fh+08h=17h with carry 0, and F5h+0Fh=04h with carry 1).
- R2: Overflow is set on add when both operands have the same sign bit and the result's sign bit differs from it (4Fh+40h=8Fh gives carry 0 and overflow 1; DAh+9Dh=77h gives carry 1 and overflow 1).
- R3: With operation code 1 (subtract), `result` is (`op_a` − `op_b`) mod 256. Carry is set when a borrow occurs (`op_a` < `op_b` as unsigned). Overflow is set when the operands' sign bits differ and the result's sign bit differs from `op_a`'s.
- R4: For every operation, the sign flag equals the result's top bit, and the zero flag is set exactly when the result is all zeros.
- R5: The nibble carry flag is set on add when bits 3..0 carry into bit 4, and on subtract when bits 3..0 borrow from bit 4. It is 0 for all other operation codes.
- R6: The parity flag is set when the result contains an even number of 1 bits, a zero result included.
- R7: Operation codes 2, 3 and 4 give bitwise AND, OR and XOR. Carry and overflow are 0 for these codes.
- R8: Flags are packed as {overflow, sign, zero, nibble carry, parity, carry} in bits 5 down to 0 of both `flags_now` and `flags_q`. Operation codes 5 to 7 give a zero result, with flags derived as for a logic operation.
- R9: When `flag_we` is high at a rising clock edge, `flags_q` takes the value of `flags_now` after that edge. When `flag_we` is low, `flags_q` keeps its value.
- R10: While `rst_n` is low, `flags_q` is 0 without waiting for a clock edge. After `rst_n` rises, writes are ignored until the third rising edge, which is the first edge at which a write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 8 | First operand (minuend for subtract) |
| op_b | input | 8 | Second operand |
| op_sel | input | 3 | Operation code |
| flag_we | input | 1 | Status register write enable |
| result | output | 8 | Combinational result |
| flags_now | output | 6 | Combinational flags for the current operation |
| flags_q | output | 6 | Registered status flags |

## Verification
The bench drives the four carry/overflow combinations on add, because a unit that derives overflow from carry would get 4Fh+40h or F5h+0Fh wrong. Subtract cases cover a borrow without overflow, overflow both with and without a borrow, and a difference of zero. These cases expose a carry polarity that is not inverted, or an overflow rule copied unchanged from add. A zero result must set parity, and single-bit and seven-bit results must clear it, which catches an inverted parity sense. Directed tests show that a write during the synchronizer window is lost, that a cleared strobe holds the register, and that reset clears it at once.

// File: rtl/stat_alu_pkg.sv
`timescale 1ns/1ps
package stat_alu_pkg;
  localparam int OPW    = 3;
  localparam int NFLAGS = 6;
  localparam int NIB    = 4;   // bit that receives the nibble carry

  localparam logic [OPW-1:0] OP_ADD = 3'd0;
  localparam logic [OPW-1:0] OP_SUB = 3'd1;
  localparam logic [OPW-1:0] OP_AND = 3'd2;
  localparam logic [OPW-1:0] OP_OR  = 3'd3;
  localparam logic [OPW-1:0] OP_XOR = 3'd4;

  localparam int FL_C = 0;
  localparam int FL_P = 1;
  localparam int FL_A = 2;
  localparam int FL_Z = 3;
  localparam int FL_S = 4;
  localparam int FL_O = 5;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flags_t;
endpackage

// File: rtl/stat_alu_arith.sv
`timescale 1ns/1ps
module stat_alu_arith
  import stat_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         aux,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W:0] ext;
  logic       b_sign_eff;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b};
    else     ext = {1'b0, a} + {1'b0, b};
    sum        = ext[W-1:0];
    cout       = ext[W];
    aux        = a[NIB] ^ b[NIB] ^ ext[NIB];
    b_sign_eff = sub ? ~b[MSB] : b[MSB];
    ovf        = (a[MSB] == b_sign_eff) && (ext[MSB] != a[MSB]);
  end
endmodule

// File: rtl/stat_alu_logic.sv
`timescale 1ns/1ps
module stat_alu_logic
  import stat_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [OPW-1:0] op,
  output logic [W-1:0]   res
);
  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/stat_alu_flagreg.sv
`timescale 1ns/1ps
module stat_alu_flagreg
  import stat_alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   we,
  input  flags_t d,
  output flags_t q,
  output logic   rst_sync_n
);
  logic   sync_1;
  logic   sync_2;
  flags_t q_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_1 <= 1'b0;
      sync_2 <= 1'b0;
    end else begin
      sync_1 <= 1'b1;
      sync_2 <= sync_1;
    end
  end

  assign rst_sync_n = sync_2;

  always_comb begin
    q_d = q;
    if (we && sync_2) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/stat_alu.sv
`timescale 1ns/1ps
module stat_alu
  import stat_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [OPW-1:0]    op_sel,
  input  logic              flag_we,
  output logic [W-1:0]      result,
  output logic [NFLAGS-1:0] flags_now,
  output logic [NFLAGS-1:0] flags_q
);
  logic [W-1:0] arith_sum;
  logic [W-1:0] logic_res;
  logic         arith_cry;
  logic         arith_aux;
  logic         arith_ovf;
  logic         is_arith;
  flags_t       fl_comb;
  flags_t       fl_reg;
  logic         rst_sync_n;

  stat_alu_arith #(.W(W)) u_arith (
    .a    (op_a),
    .b    (op_b),
    .sub  (op_sel == OP_SUB),
    .sum  (arith_sum),
    .cout (arith_cry),
    .aux  (arith_aux),
    .ovf  (arith_ovf)
  );

  stat_alu_logic #(.W(W)) u_logic (
    .a   (op_a),
    .b   (op_b),
    .op  (op_sel),
    .res (logic_res)
  );

  always_comb begin
    is_arith    = (op_sel == OP_ADD) || (op_sel == OP_SUB);
    result      = is_arith ? arith_sum : logic_res;
    fl_comb.cry = is_arith & arith_cry;
    fl_comb.ovf = is_arith & arith_ovf;
    fl_comb.aux = is_arith & arith_aux;
    fl_comb.sgn = result[W-1];
    fl_comb.zro = ~|result;
    fl_comb.par = ~^result;
  end

  assign flags_now = fl_comb;

  stat_alu_flagreg u_flagreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (flag_we),
    .d          (fl_comb),
    .q          (fl_reg),
    .rst_sync_n (rst_sync_n)
  );

  assign flags_q = fl_reg;
endmodule

// File: rtl/stat_alu_chk.sv
`timescale 1ns/1ps
module stat_alu_chk
  import stat_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_q,
  input logic [OPW-1:0]    op_sel,
  input logic              flag_we,
  input logic [W-1:0]      result,
  input logic [NFLAGS-1:0] flags_now,
  input logic [NFLAGS-1:0] flags_q
);
  a_r9_write: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && rst_q) |=> (flags_q == $past(flags_now)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags_q));

  a_r10_sync_block: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q |=> $stable(flags_q));

  a_r7_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OP_SUB) |-> (!flags_now[FL_C] && !flags_now[FL_O] && !flags_now[FL_A]));

  a_r4_sign: assert property (@(posedge clk) disable iff (!rst_n)
    flags_now[FL_S] == result[W-1]);

  a_r6_parity: assert property (@(posedge clk) disable iff (!rst_n)
    flags_now[FL_P] == ~^result);

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OP_XOR) |-> (result == '0));
endmodule

bind stat_alu stat_alu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_q     (rst_sync_n),
  .op_sel    (op_sel),
  .flag_we   (flag_we),
  .result    (result),
  .flags_now (flags_now),
  .flags_q   (flags_q)
);

// File: tb/stat_alu_bench.sv
`timescale 1ns/1ps
module stat_alu_bench;
  localparam int NV = 16;
  // {op[2:0], a[7:0], b[7:0], result[7:0], flags {O,S,Z,A,P,C}}
  localparam logic [32:0] VEC [NV] = '{
    {3'd0, 8'h4F, 8'h40, 8'h8F, 6'b110000},
    {3'd0, 8'hDA, 8'h9D, 8'h77, 6'b100111},
    {3'd0, 8'h0F, 8'h08, 8'h17, 6'b000110},
    {3'd0, 8'hF5, 8'h0F, 8'h04, 6'b000101},
    {3'd0, 8'h80, 8'h80, 8'h00, 6'b101011},
    {3'd0, 8'hFF, 8'h01, 8'h00, 6'b001111},
    {3'd1, 8'h05, 8'h07, 8'hFE, 6'b010101},
    {3'd1, 8'h80, 8'h01, 8'h7F, 6'b100100},
    {3'd1, 8'h7F, 8'hFF, 8'h80, 6'b110001},
    {3'd1, 8'h3C, 8'h3C, 8'h00, 6'b001010},
    {3'd2, 8'hF0, 8'h3C, 8'h30, 6'b000010},
    {3'd3, 8'h81, 8'h02, 8'h83, 6'b010000},
    {3'd4, 8'hAA, 8'hAA, 8'h00, 6'b001010},
    {3'd4, 8'h55, 8'h0F, 8'h5A, 6'b000010},
    {3'd2, 8'h0F, 8'hF0, 8'h00, 6'b001010},
    {3'd5, 8'hA5, 8'h5A, 8'h00, 6'b001010}
  };

  logic       clk;
  logic       rst_n;
  logic [7:0] op_a;
  logic [7:0] op_b;
  logic [2:0] op_sel;
  logic       flag_we;
  logic [7:0] result;
  logic [5:0] flags_now;
  logic [5:0] flags_q;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  stat_alu u_stat_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .flag_we   (flag_we),
    .result    (result),
    .flags_now (flags_now),
    .flags_q   (flags_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [32:0] v, input logic we);
    op_sel  = v[32:30];
    op_a    = v[29:22];
    op_b    = v[21:14];
    flag_we = we;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    apply(VEC[4], 1'b1);
    repeat (2) @(negedge clk);
    check("R10 flags in reset", {2'b0, flags_q}, 8'h00);
    // release; writes during the synchronizer window are lost
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10 window edge 1", {2'b0, flags_q}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R10 window edge 2", {2'b0, flags_q}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R10 first write edge", {2'b0, flags_q}, {2'b0, VEC[4][5:0]});

    for (int i = 0; i < NV; i++) begin
      string rtag;
      apply(VEC[i], 1'b1);
      case (VEC[i][32:30])
        3'd0:    rtag = "R1 add result";
        3'd1:    rtag = "R3 sub result";
        3'd2, 3'd3, 3'd4: rtag = "R7 logic result";
        default: rtag = "R8 unused code result";
      endcase
      #1;
      check(rtag, result, VEC[i][13:6]);
      check("R2 R3 R4 R5 R6 R7 R8 flags", {2'b0, flags_now}, {2'b0, VEC[i][5:0]});
      @(posedge clk); @(negedge clk);
      check("R9 registered flags", {2'b0, flags_q}, {2'b0, VEC[i][5:0]});
    end

    // R9: hold with strobe low
    apply(VEC[1], 1'b1);
    @(posedge clk); @(negedge clk);
    apply(VEC[12], 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 hold when strobe low", {2'b0, flags_q}, {2'b0, VEC[1][5:0]});
    #1;
    check("R6 zero result parity", {7'b0, flags_now[1]}, 8'h01);

    // R10: asynchronous clear mid-run
    rst_n = 1'b0;
    #0.5;
    check("R10 async clear", {2'b0, flags_q}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule